// File: doc/BRIEF.md
# Power-On Reset and Output-Enable Sequencer

This block owns the chip-level reset of a video decoder and the enables of its output drivers. Three conditions hold the chip in reset: the clock monitor reporting no clock, the supply comparator reporting a low supply (below about 2.7 V), and the active-high chip-enable pin being pulled low. Any one of them resets the chip at once, without waiting for a clock edge, and every output enable drops so that all pins float.

Release is synchronous. Once all three conditions are clear, a two-flop synchronizer and a qualification counter make sure the clock has run cleanly for a set time before the internal reset is lifted. The two clock-output enables and the serial-data enable then return on their own. The remaining output group stays off until software writes its enable bits, and every reset clears those bits again. A reset indicator for the board then stays low for a counted number of cycles after the internal release. A new reset condition during that count restarts the whole sequence.

Top module: `pos_sequencer`

## Requirements
- R1: Any of `clk_alive_i` low, `supply_ok_i` low or `chip_en_i` low drives `rst_int_n_o` low in the same time step, with no clock edge needed.
- R2: While `rst_int_n_o` is low, `clk_oe_o`, `sda_oe_o` and `grp_oe_o` are all zero.
- R3: When all three conditions become good between two clock edges and stay good, `rst_int_n_o` rises on the 11th rising edge that follows: 2 synchronizer edges, 8 qualification edges (HOLD) and 1 output register edge.
- R4: If a condition returns while the release count is running, the count starts again from zero, and the next release once more takes 11 edges.
- R5: `rst_ext_n_o` is low whenever `rst_int_n_o` is low, and it rises exactly 128 (PULSE) rising edges after the edge on which `rst_int_n_o` rose.
- R6: A condition that appears while the 128-cycle count is running pulls `rst_ext_n_o` low again, and after the next release the full 128 edges are counted again.
- R7: From the edge on which `rst_int_n_o` rises, `clk_oe_o` is 2'b11 and `sda_oe_o` is 1, with no programming needed.
- R8: After release, `grp_oe_o` is zero until a write. A write is `prog_wr_i` high on a rising edge, and it loads `prog_data_i` bit for bit, so bit k enables output k from that edge on. Without a write, `grp_oe_o` does not change.
- R9: A write made while `rst_int_n_o` is low is ignored, so `grp_oe_o` is zero after the release that follows.
- R10: Every reset clears the programmed enables, so `grp_oe_o` is zero after any release until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| clk_alive_i | input | 1 | Clock monitor result, high while the clock is running |
| supply_ok_i | input | 1 | Supply comparator result, high while the supply is above threshold |
| chip_en_i | input | 1 | Chip-enable pin, active high |
| prog_wr_i | input | 1 | Write strobe for the programmed output enables |
| prog_data_i | input | N_GRP | Enable bits for the programmable output group |
| rst_int_n_o | output | 1 | Internal reset, active low |
| rst_ext_n_o | output | 1 | Board-level reset indicator, active low |
| clk_oe_o | output | 2 | Enables of the two clock output drivers |
| sda_oe_o | output | 1 | Enable of the serial data output driver |
| grp_oe_o | output | N_GRP | Enables of the programmable output group |

## Verification
Each of the three reset conditions is dropped on its own, between clock edges, to show that R1 and R2 act without a clock and that no single condition is left out. Release timing is measured by counting edges from a clean release and from a release interrupted partway through, which separates a count that restarts from one that merely pauses. The pulse indicator is measured after a clean release and after a condition that arrives mid-pulse. Enable writes are made during reset, after release and after a later reset, which tells a register that ignores writes during reset and is cleared by reset apart from one that merely masks its output.

// File: rtl/pos_pkg.sv
package pos_pkg;
    localparam int CLK_PINS      = 2;
    localparam int DEF_HOLD      = 8;
    localparam int DEF_PULSE     = 128;

    typedef struct packed {
        logic [CLK_PINS-1:0] clk_oe;
        logic                sda_oe;
    } fixed_oe_t;
endpackage

// File: rtl/pos_cond_sync.sv
module pos_cond_sync #(
    parameter int HOLD = 8
) (
    input  logic clk,
    input  logic cond_i,
    output logic rst_n_o
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] hold;
        logic          rel;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], 1'b1};
        if (st_q.sync[1] && (st_q.hold != HOLD_V)) begin
            st_d.hold = st_q.hold + 1'b1;
        end
        st_d.rel  = (st_q.hold == HOLD_V);
    end

    always_ff @(posedge clk or posedge cond_i) begin
        if (cond_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_n_o = st_q.rel;
endmodule

// File: rtl/pos_pulse_timer.sv
module pos_pulse_timer #(
    parameter int PULSE = 128
) (
    input  logic clk,
    input  logic rst_int_n_i,
    output logic rst_ext_n_o
);
    localparam int CW = (PULSE > 2) ? $clog2(PULSE) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(PULSE - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.done = st_q.done | (st_q.cnt == LAST_V);
    end

    always_ff @(posedge clk or negedge rst_int_n_i) begin
        if (!rst_int_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_ext_n_o = st_q.done;
endmodule

// File: rtl/pos_oe_ctrl.sv
module pos_oe_ctrl
    import pos_pkg::*;
#(
    parameter int N_GRP = 6
) (
    input  logic             clk,
    input  logic             rst_int_n_i,
    input  logic             wr_i,
    input  logic [N_GRP-1:0] data_i,
    output fixed_oe_t        fixed_oe_o,
    output logic [N_GRP-1:0] grp_oe_o
);
    typedef struct packed {
        logic [N_GRP-1:0] prog;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.prog = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_int_n_i) begin
        if (!rst_int_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        fixed_oe_o.clk_oe = {CLK_PINS{rst_int_n_i}};
        fixed_oe_o.sda_oe = rst_int_n_i;
        grp_oe_o          = st_q.prog & {N_GRP{rst_int_n_i}};
    end
endmodule

// File: rtl/pos_sequencer.sv
module pos_sequencer
    import pos_pkg::*;
#(
    parameter int N_GRP = 6,
    parameter int HOLD  = DEF_HOLD,
    parameter int PULSE = DEF_PULSE
) (
    input  logic                clk,
    input  logic                clk_alive_i,
    input  logic                supply_ok_i,
    input  logic                chip_en_i,
    input  logic                prog_wr_i,
    input  logic [N_GRP-1:0]    prog_data_i,
    output logic                rst_int_n_o,
    output logic                rst_ext_n_o,
    output logic [CLK_PINS-1:0] clk_oe_o,
    output logic                sda_oe_o,
    output logic [N_GRP-1:0]    grp_oe_o
);
    logic      cond_async;
    logic      rst_int_n;
    fixed_oe_t fixed_oe;

    assign cond_async = !clk_alive_i || !supply_ok_i || !chip_en_i;

    pos_cond_sync #(.HOLD(HOLD)) u_sync (
        .clk     (clk),
        .cond_i  (cond_async),
        .rst_n_o (rst_int_n)
    );

    pos_pulse_timer #(.PULSE(PULSE)) u_pulse (
        .clk         (clk),
        .rst_int_n_i (rst_int_n),
        .rst_ext_n_o (rst_ext_n_o)
    );

    pos_oe_ctrl #(.N_GRP(N_GRP)) u_oe (
        .clk         (clk),
        .rst_int_n_i (rst_int_n),
        .wr_i        (prog_wr_i),
        .data_i      (prog_data_i),
        .fixed_oe_o  (fixed_oe),
        .grp_oe_o    (grp_oe_o)
    );

    assign rst_int_n_o = rst_int_n;
    assign clk_oe_o    = fixed_oe.clk_oe;
    assign sda_oe_o    = fixed_oe.sda_oe;
endmodule

// File: rtl/pos_sequencer_chk.sv
module pos_sequencer_chk #(
    parameter int N_GRP = 6,
    parameter int PULSE = 128
) (
    input logic             clk,
    input logic             clk_alive_i,
    input logic             supply_ok_i,
    input logic             chip_en_i,
    input logic             prog_wr_i,
    input logic             rst_int_n_o,
    input logic             rst_ext_n_o,
    input logic [1:0]       clk_oe_o,
    input logic             sda_oe_o,
    input logic [N_GRP-1:0] grp_oe_o
);
    localparam int CW = $clog2(PULSE + 2) + 1;
    localparam logic [CW-1:0] MAX_V   = {CW{1'b1}};
    localparam logic [CW-1:0] PULSE_V = CW'(PULSE);

    logic          cond;
    logic [CW-1:0] hi_cnt;

    assign cond = !clk_alive_i || !supply_ok_i || !chip_en_i;

    always_ff @(posedge clk) begin
        if (!rst_int_n_o) begin
            hi_cnt <= '0;
        end else if (hi_cnt != MAX_V) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assert_cond_forces_reset_R1: assert property (@(posedge clk)
        cond |-> !rst_int_n_o);

    assert_oe_off_in_reset_R2: assert property (@(posedge clk)
        !rst_int_n_o |-> (clk_oe_o == 2'b00) && !sda_oe_o && (grp_oe_o == '0));

    assert_release_when_good_R3: assert property (@(posedge clk) disable iff (cond)
        $rose(rst_int_n_o) |-> $past(clk_alive_i && supply_ok_i && chip_en_i));

    assert_ext_follows_int_R5: assert property (@(posedge clk)
        rst_ext_n_o |-> rst_int_n_o);

    assert_ext_width_R5: assert property (@(posedge clk) disable iff (cond)
        $rose(rst_ext_n_o) |-> (hi_cnt == PULSE_V));

    assert_fixed_on_R7: assert property (@(posedge clk) disable iff (cond)
        rst_int_n_o |-> (clk_oe_o == 2'b11) && sda_oe_o);

    assert_grp_write_only_R8: assert property (@(posedge clk) disable iff (!rst_int_n_o)
        !$past(prog_wr_i) |-> $stable(grp_oe_o));
endmodule

bind pos_sequencer pos_sequencer_chk #(.N_GRP(N_GRP), .PULSE(PULSE)) u_chk (
    .clk         (clk),
    .clk_alive_i (clk_alive_i),
    .supply_ok_i (supply_ok_i),
    .chip_en_i   (chip_en_i),
    .prog_wr_i   (prog_wr_i),
    .rst_int_n_o (rst_int_n_o),
    .rst_ext_n_o (rst_ext_n_o),
    .clk_oe_o    (clk_oe_o),
    .sda_oe_o    (sda_oe_o),
    .grp_oe_o    (grp_oe_o)
);

// File: tb/pos_sequencer_bench.sv
module pos_sequencer_bench;
    localparam int N_GRP   = 6;
    localparam int RELEASE = 11;
    localparam int PULSE   = 128;

    logic             clk = 1'b0;
    logic             clk_alive_i = 1'b0;
    logic             supply_ok_i = 1'b0;
    logic             chip_en_i = 1'b0;
    logic             prog_wr_i = 1'b0;
    logic [N_GRP-1:0] prog_data_i = '0;
    logic             rst_int_n_o;
    logic             rst_ext_n_o;
    logic [1:0]       clk_oe_o;
    logic             sda_oe_o;
    logic [N_GRP-1:0] grp_oe_o;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    pos_sequencer #(.N_GRP(N_GRP)) u_pos_sequencer (
        .clk         (clk),
        .clk_alive_i (clk_alive_i),
        .supply_ok_i (supply_ok_i),
        .chip_en_i   (chip_en_i),
        .prog_wr_i   (prog_wr_i),
        .prog_data_i (prog_data_i),
        .rst_int_n_o (rst_int_n_o),
        .rst_ext_n_o (rst_ext_n_o),
        .clk_oe_o    (clk_oe_o),
        .sda_oe_o    (sda_oe_o),
        .grp_oe_o    (grp_oe_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic set_all_good();
        @(negedge clk);
        clk_alive_i = 1'b1;
        supply_ok_i = 1'b1;
        chip_en_i   = 1'b1;
    endtask

    task automatic measure_release(output int n);
        n = 0;
        while (!rst_int_n_o && n < 40) begin
            @(posedge clk);
            #1;
            n++;
        end
    endtask

    task automatic measure_ext(output int n);
        n = 0;
        while (!rst_ext_n_o && n < 300) begin
            @(posedge clk);
            #1;
            n++;
        end
    endtask

    task automatic all_oe_off(input string req);
        check(clk_oe_o == 2'b00, req, "clk_oe in reset", int'(clk_oe_o), 0);
        check(!sda_oe_o, req, "sda_oe in reset", int'(sda_oe_o), 0);
        check(grp_oe_o == '0, req, "grp_oe in reset", int'(grp_oe_o), 0);
    endtask

    task automatic write_grp(input logic [N_GRP-1:0] val);
        @(negedge clk);
        prog_wr_i   = 1'b1;
        prog_data_i = val;
        @(negedge clk);
        prog_wr_i   = 1'b0;
        prog_data_i = '0;
    endtask

    task automatic t_reset_state();
        #1;
        check(!rst_int_n_o, "R1", "rst_int at start", int'(rst_int_n_o), 0);
        check(!rst_ext_n_o, "R5", "rst_ext at start", int'(rst_ext_n_o), 0);
        all_oe_off("R2");
    endtask

    task automatic t_release_and_pulse();
        int n;
        int m;
        set_all_good();
        measure_release(n);
        check(n == RELEASE, "R3", "edges to release", n, RELEASE);
        check(clk_oe_o == 2'b11, "R7", "clk_oe after release", int'(clk_oe_o), 3);
        check(sda_oe_o, "R7", "sda_oe after release", int'(sda_oe_o), 1);
        check(grp_oe_o == '0, "R8", "grp_oe before write", int'(grp_oe_o), 0);
        check(!rst_ext_n_o, "R5", "rst_ext right after release", int'(rst_ext_n_o), 0);
        measure_ext(m);
        check(m == PULSE, "R5", "edges to rst_ext", m, PULSE);
    endtask

    task automatic t_prog_write();
        write_grp(6'b101101);
        check(grp_oe_o == 6'b101101, "R8", "grp_oe after write", int'(grp_oe_o), 45);
        repeat (3) @(posedge clk);
        #1;
        check(grp_oe_o == 6'b101101, "R8", "grp_oe held", int'(grp_oe_o), 45);
        write_grp(6'b010011);
        check(grp_oe_o == 6'b010011, "R8", "grp_oe second write", int'(grp_oe_o), 19);
    endtask

    task automatic t_each_condition();
        int n;
        for (int k = 0; k < 3; k++) begin
            write_grp(6'b111111);
            @(negedge clk);
            #1;
            case (k)
                0: clk_alive_i = 1'b0;
                1: supply_ok_i = 1'b0;
                default: chip_en_i = 1'b0;
            endcase
            #1;
            check(!rst_int_n_o, "R1", $sformatf("immediate reset cond %0d", k), int'(rst_int_n_o), 0);
            check(!rst_ext_n_o, "R5", "rst_ext low with rst_int", int'(rst_ext_n_o), 0);
            all_oe_off("R2");
            repeat (2) @(posedge clk);
            set_all_good();
            measure_release(n);
            check(n == RELEASE, "R3", "edges to release", n, RELEASE);
            check(grp_oe_o == '0, "R10", "grp cleared by reset", int'(grp_oe_o), 0);
        end
    endtask

    task automatic t_write_in_reset();
        int n;
        @(negedge clk);
        supply_ok_i = 1'b0;
        write_grp(6'b110110);
        set_all_good();
        write_grp(6'b011001);
        measure_release(n);
        check(grp_oe_o == '0, "R9", "write in reset ignored", int'(grp_oe_o), 0);
    endtask

    task automatic t_restart_countdown();
        int n;
        @(negedge clk);
        chip_en_i = 1'b0;
        repeat (2) @(posedge clk);
        set_all_good();
        repeat (6) @(posedge clk);
        #1;
        check(!rst_int_n_o, "R4", "still in reset mid-count", int'(rst_int_n_o), 0);
        @(negedge clk);
        clk_alive_i = 1'b0;
        @(negedge clk);
        clk_alive_i = 1'b1;
        measure_release(n);
        check(n == RELEASE, "R4", "edges after interrupted count", n, RELEASE);
    endtask

    task automatic t_pulse_restart();
        int n;
        int m;
        measure_ext(m);
        @(negedge clk);
        chip_en_i = 1'b0;
        repeat (2) @(posedge clk);
        set_all_good();
        measure_release(n);
        repeat (60) @(posedge clk);
        #1;
        check(!rst_ext_n_o, "R6", "rst_ext low mid-pulse", int'(rst_ext_n_o), 0);
        @(negedge clk);
        #1;
        supply_ok_i = 1'b0;
        #1;
        check(!rst_ext_n_o, "R6", "rst_ext after new condition", int'(rst_ext_n_o), 0);
        set_all_good();
        measure_release(n);
        check(n == RELEASE, "R6", "release after pulse restart", n, RELEASE);
        measure_ext(m);
        check(m == PULSE, "R6", "full pulse recounted", m, PULSE);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        t_reset_state();
        t_release_and_pulse();
        t_prog_write();
        t_each_condition();
        t_write_in_reset();
        t_restart_countdown();
        t_pulse_restart();
        report();
        $finish;
    end
endmodule